// File: doc/BRIEF.md
# Rectangle Fill Engine

This block erases a rectangle of an 8-bit-per-pixel framebuffer. A command is handed over as five parallel 32-bit words: the command word, a line-width word, an attribute word and two vertex words. A one-cycle `start` pulse captures them. If the command word carries the fill code, the engine derives the rectangle bounds and a grey level. It then writes that grey level into every pixel of the region through a write-only synchronous memory port, one pixel per clock.

The engine also keeps a dirty-region bounding box. This box only grows, and a display refresh path can use it to limit what it redraws. `busy` covers the time spent walking the region. `done` marks the end of each accepted command, including commands whose region turns out to be empty.

Top module: `rfill_engine`

## Requirements
- R1: A command is accepted only when `start` is high, `busy` is low and `cmd_word` equals 0x411. A start pulse with any other command word, or a start pulse while busy, causes no write, no `done` and no change to the dirty box.
- R2: Before any field is extracted, the raw line-width word is subtracted (modulo 2^32) from each vertex word. From the result, x is taken from bits 29:19 (11 bits) and y from bits 12:3 (10 bits). Vertex 1 gives (x, y) and vertex 2 gives (x2, y2).
- R3: Let q = (lw + 1) >> 2, where lw is treated as a signed 32-bit value and the shift is arithmetic. The rows written run from y up to, but not including, y2 + q. That end value is capped at 1024.
- R4: The columns written run from x up to, but not including, min(x2, 1280). This cap also covers the case where x2 - x exceeds 1280.
- R5: The pixel value depends on bits 23:16 of the attribute word. A code of 0 writes 0, a code of 7 writes 192, and every other code writes 255.
- R6: Exactly one write is made per pixel, in raster order: columns ascending within a row, then rows ascending. The write address is row*1280 + column, and a write is issued every clock while the region is being walked.
- R7: After reset, `busy`, `done` and `fb_we` are 0. `busy` rises in the cycle after acceptance of a non-empty command. `done` is a one-cycle pulse that appears together with the last write, and `busy` is low in that cycle.
- R8: A command whose column range or row range is empty makes no writes. It pulses `done` in the cycle after acceptance and never raises `busy`.
- R9: After reset, the dirty box holds x_min=2047, x_max=0, y_min=1023 and y_max=0. Every accepted command, even an empty one, widens x_min by x and x_max by the capped column end. Each row that is written widens y_min and y_max by its row number, and this becomes visible no later than the first write of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the command words |
| cmd_word | input | 32 | Command code |
| lw_word | input | 32 | Line-width word |
| attr_word | input | 32 | Attribute word (intensity code in bits 23:16) |
| v1_word | input | 32 | Packed first vertex |
| v2_word | input | 32 | Packed second vertex |
| busy | output | 1 | Region walk in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| fb_we | output | 1 | Framebuffer write enable |
| fb_addr | output | 21 | Framebuffer pixel address |
| fb_wdata | output | 8 | Pixel value |
| dirty_x_min | output | 11 | Dirty box left edge |
| dirty_x_max | output | 11 | Dirty box right edge (exclusive column end) |
| dirty_y_min | output | 10 | Dirty box top row |
| dirty_y_max | output | 10 | Dirty box bottom row |

## Verification
The bench aims at the points where the arithmetic is easy to get wrong:
- A nonzero line width. If the subtraction before extraction were dropped, every pixel would land one or two rows off. If the rounding of q were wrong, a row would be added or lost.
- A negative line width that empties the row range. Shifting logically instead of arithmetically would flood hundreds of rows.
- An over-wide span that reaches the 1280 cap, and a span that reaches the row cap at 1024. Without the caps, writes would spill past the frame.
- An empty range issued straight after reset, which exposes a dirty box that skips the x update or writes anyway.
- A wrong command code and a start pulse during a walk. Either one, if not ignored, shows up as unexpected writes after `done`.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

  // Field widths fixed by the packed vertex format
  localparam int X_W   = 11;
  localparam int Y_W   = 10;
  localparam int END_W = 11;
  localparam int PIX_W = 8;

  typedef struct packed {
    logic [X_W-1:0]   x_lo;
    logic [END_W-1:0] x_end;
    logic [Y_W-1:0]   y_lo;
    logic [END_W-1:0] y_end;
    logic [PIX_W-1:0] color;
    logic             empty;
  } rect_t;

  // Three-level grey from the attribute code
  function automatic logic [PIX_W-1:0] grey_of(input logic [7:0] code);
    if (code == 8'd0)      return PIX_W'(0);
    else if (code == 8'd7) return PIX_W'(192);
    else                   return {PIX_W{1'b1}};
  endfunction

endpackage

// File: rtl/rfill_decode.sv
module rfill_decode
  import rfill_pkg::*;
#(
  parameter int FB_W = 1280,
  parameter int FB_H = 1024
) (
  input  logic [31:0] lw_word,
  input  logic [31:0] attr_word,
  input  logic [31:0] v1_word,
  input  logic [31:0] v2_word,
  output rect_t       rect
);

  localparam logic signed [33:0] H_LIM = 34'(FB_H);
  localparam logic [END_W-1:0]   W_LIM = END_W'(FB_W);

  logic [31:0]         adj1, adj2;
  logic [X_W-1:0]      xa, xb;
  logic [Y_W-1:0]      ya, yb;
  logic signed [33:0]  lw_q, y_stop;
  logic [END_W-1:0]    xe, ye;

  always_comb begin
    adj1   = v1_word - lw_word;
    adj2   = v2_word - lw_word;
    xa     = adj1[29:19];
    ya     = adj1[12:3];
    xb     = adj2[29:19];
    yb     = adj2[12:3];
    lw_q   = ($signed({{2{lw_word[31]}}, lw_word}) + 34'sd1) >>> 2;
    y_stop = $signed({24'd0, yb}) + lw_q;
    if (y_stop > H_LIM)         ye = END_W'(FB_H);
    else if (y_stop < 34'sd0)   ye = '0;
    else                        ye = y_stop[END_W-1:0];
    xe = (xb > W_LIM) ? W_LIM : xb;

    rect.x_lo  = xa;
    rect.x_end = xe;
    rect.y_lo  = ya;
    rect.y_end = ye;
    rect.color = grey_of(attr_word[23:16]);
    rect.empty = (xe <= END_W'(xa)) || (ye <= END_W'(ya));
  end

endmodule

// File: rtl/rfill_walker.sv
module rfill_walker
  import rfill_pkg::*;
#(
  parameter int FB_W   = 1280,
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  rect_t             rect,
  output logic              busy,
  output logic              done,
  output logic              fb_we,
  output logic [ADDR_W-1:0] fb_addr,
  output logic [PIX_W-1:0]  fb_wdata,
  output logic              row_ev,
  output logic [Y_W-1:0]    row_y
);

  logic              run;
  logic [X_W-1:0]    col;
  logic [Y_W-1:0]    row;
  logic [ADDR_W-1:0] base;
  logic [X_W-1:0]    x_lo;
  logic [END_W-1:0]  x_end, y_end;
  logic [PIX_W-1:0]  color;
  logic              last_col, last_row;

  assign last_col = (END_W'(col) == x_end - END_W'(1));
  assign last_row = (END_W'(row) == y_end - END_W'(1));
  assign row_ev   = run && (col == x_lo);
  assign row_y    = row;
  assign busy     = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      done     <= 1'b0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
      col      <= '0;
      row      <= '0;
      base     <= '0;
      x_lo     <= '0;
      x_end    <= '0;
      y_end    <= '0;
      color    <= '0;
    end else begin
      fb_we <= 1'b0;
      done  <= 1'b0;
      if (load) begin
        col   <= rect.x_lo;
        row   <= rect.y_lo;
        base  <= ADDR_W'(rect.y_lo) * ADDR_W'(FB_W);
        x_lo  <= rect.x_lo;
        x_end <= rect.x_end;
        y_end <= rect.y_end;
        color <= rect.color;
        run   <= ~rect.empty;
        done  <= rect.empty;
      end else if (run) begin
        fb_we    <= 1'b1;
        fb_addr  <= base + ADDR_W'(col);
        fb_wdata <= color;
        if (last_col) begin
          col  <= x_lo;
          row  <= row + Y_W'(1);
          base <= base + ADDR_W'(FB_W);
          if (last_row) begin
            run  <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          col <= col + X_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rfill_dirty.sv
module rfill_dirty
  import rfill_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [X_W-1:0]   x_lo,
  input  logic [END_W-1:0] x_end,
  input  logic             row_ev,
  input  logic [Y_W-1:0]   row_y,
  output logic [X_W-1:0]   x_min,
  output logic [END_W-1:0] x_max,
  output logic [Y_W-1:0]   y_min,
  output logic [Y_W-1:0]   y_max
);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_min <= '1;
      x_max <= '0;
      y_min <= '1;
      y_max <= '0;
    end else begin
      if (load) begin
        if (x_lo < x_min)  x_min <= x_lo;
        if (x_end > x_max) x_max <= x_end;
      end
      if (row_ev) begin
        if (row_y < y_min) y_min <= row_y;
        if (row_y > y_max) y_max <= row_y;
      end
    end
  end

endmodule

// File: rtl/rfill_engine.sv
module rfill_engine
  import rfill_pkg::*;
#(
  parameter int          FB_W     = 1280,
  parameter int          FB_H     = 1024,
  parameter logic [31:0] FILL_CMD = 32'h0000_0411
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [31:0]                      cmd_word,
  input  logic [31:0]                      lw_word,
  input  logic [31:0]                      attr_word,
  input  logic [31:0]                      v1_word,
  input  logic [31:0]                      v2_word,
  output logic                             busy,
  output logic                             done,
  output logic                             fb_we,
  output logic [$clog2(FB_W*FB_H)-1:0]     fb_addr,
  output logic [rfill_pkg::PIX_W-1:0]      fb_wdata,
  output logic [rfill_pkg::X_W-1:0]        dirty_x_min,
  output logic [rfill_pkg::END_W-1:0]      dirty_x_max,
  output logic [rfill_pkg::Y_W-1:0]        dirty_y_min,
  output logic [rfill_pkg::Y_W-1:0]        dirty_y_max
);

  localparam int ADDR_W = $clog2(FB_W*FB_H);

  rect_t          rect;
  logic           load;
  logic           row_ev;
  logic [Y_W-1:0] row_y;

  assign load = start && !busy && (cmd_word == FILL_CMD);

  rfill_decode #(.FB_W(FB_W), .FB_H(FB_H)) u_decode (
    .lw_word  (lw_word),
    .attr_word(attr_word),
    .v1_word  (v1_word),
    .v2_word  (v2_word),
    .rect     (rect)
  );

  rfill_walker #(.FB_W(FB_W), .ADDR_W(ADDR_W)) u_walker (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .rect    (rect),
    .busy    (busy),
    .done    (done),
    .fb_we   (fb_we),
    .fb_addr (fb_addr),
    .fb_wdata(fb_wdata),
    .row_ev  (row_ev),
    .row_y   (row_y)
  );

  rfill_dirty u_dirty (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .x_lo  (rect.x_lo),
    .x_end (rect.x_end),
    .row_ev(row_ev),
    .row_y (row_y),
    .x_min (dirty_x_min),
    .x_max (dirty_x_max),
    .y_min (dirty_y_min),
    .y_max (dirty_y_max)
  );

endmodule

// File: rtl/rfill_engine_chk.sv
module rfill_engine_chk #(
  parameter int FB_W   = 1280,
  parameter int FB_H   = 1024,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              fb_we,
  input logic [ADDR_W-1:0] fb_addr,
  input logic [7:0]        fb_wdata,
  input logic [10:0]       dirty_x_min,
  input logic [9:0]        dirty_y_min
);

  localparam logic [ADDR_W-1:0] LAST_PIX = ADDR_W'(FB_W*FB_H - 1);

  // R6
  addr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (fb_addr <= LAST_PIX));

  // R5
  grey_level_chk: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> (fb_wdata == 8'd0 || fb_wdata == 8'd192 || fb_wdata == 8'd255));

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  write_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> $past(busy));

  // R9
  x_min_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dirty_x_min <= $past(dirty_x_min)));

  // R9
  y_min_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dirty_y_min <= $past(dirty_y_min)));

endmodule

bind rfill_engine rfill_engine_chk #(.FB_W(FB_W), .FB_H(FB_H), .ADDR_W($clog2(FB_W*FB_H))) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .fb_we      (fb_we),
  .fb_addr    (fb_addr),
  .fb_wdata   (fb_wdata),
  .dirty_x_min(dirty_x_min),
  .dirty_y_min(dirty_y_min)
);

// File: tb/rfill_engine_tb.sv
module rfill_engine_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] cmd_word, lw_word, attr_word, v1_word, v2_word;
  logic        busy, done, fb_we;
  logic [20:0] fb_addr;
  logic [7:0]  fb_wdata;
  logic [10:0] dirty_x_min, dirty_x_max;
  logic [9:0]  dirty_y_min, dirty_y_max;

  always #4 clk = ~clk;

  rfill_engine u_dut (.*);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct { int addr; int data; string tag; } wr_t;
  wr_t exp_q[$];

  int ex_xmin = 2047, ex_xmax = 0, ex_ymin = 1023, ex_ymax = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_v(input int x, input int y, input int lw);
    return (32'(x) << 19) + (32'(y) << 3) + 32'(lw);
  endfunction

  // Monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (!rst && fb_we) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1/R6 unexpected write actual=%0d expected=none", fb_addr);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk({e.tag, " R6 addr"}, int'(fb_addr), e.addr);
        chk({e.tag, " R5 data"}, int'(fb_wdata), e.data);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Driver: computes the expected writes from the requirements, then issues the command
  task automatic fill(input string tag, input int x, input int y, input int x2, input int y2,
                      input int lw, input int code, input bit busy_poke);
    int q, ye, xe, grey, nw;
    q  = (lw + 1) >>> 2;                       // R3
    ye = y2 + q; if (ye > 1024) ye = 1024;
    xe = (x2 > 1280) ? 1280 : x2;              // R4
    grey = (code == 0) ? 0 : (code == 7) ? 192 : 255;
    nw = 0;
    for (int r = y; r < ye; r++)
      for (int c = x; c < xe; c++) begin
        wr_t w; w.addr = r*1280 + c; w.data = grey; w.tag = tag;
        exp_q.push_back(w); nw++;
      end
    if (x < ex_xmin) ex_xmin = x;
    if (xe > ex_xmax) ex_xmax = xe;
    if (nw > 0) begin
      if (y < ex_ymin) ex_ymin = y;
      if (ye - 1 > ex_ymax) ex_ymax = ye - 1;
    end
    cmd_word  = 32'h411;
    lw_word   = 32'(lw);
    attr_word = 32'(code) << 16;
    v1_word   = pack_v(x, y, lw);
    v2_word   = pack_v(x2, y2, lw);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (nw == 0) begin
      chk({tag, " R8 done after accept"}, int'(done), 1);
      chk({tag, " R8 busy stays low"}, int'(busy), 0);
    end else begin
      chk({tag, " R7 busy rises"}, int'(busy), 1);
      if (busy_poke) begin
        @(negedge clk);
        cmd_word = 32'h411; v1_word = pack_v(0, 0, 0); v2_word = pack_v(9, 9, 0);
        lw_word = 0; attr_word = 0;
        start = 1'b1;                          // R1: ignored while busy
        @(negedge clk);
        start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk({tag, " R7 busy low at done"}, int'(busy), 0);
    end
    #1;
    chk({tag, " R6 all writes seen"}, exp_q.size(), 0);
    chk({tag, " R9 x_min"}, int'(dirty_x_min), ex_xmin);
    chk({tag, " R9 x_max"}, int'(dirty_x_max), ex_xmax);
    chk({tag, " R9 y_min"}, int'(dirty_y_min), ex_ymin);
    chk({tag, " R9 y_max"}, int'(dirty_y_max), ex_ymax);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, int'(done), 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0;
    cmd_word = 0; lw_word = 0; attr_word = 0; v1_word = 0; v2_word = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset busy", int'(busy), 0);
    chk("R7 reset done", int'(done), 0);
    chk("R7 reset we", int'(fb_we), 0);
    chk("R9 reset x_min", int'(dirty_x_min), 2047);
    chk("R9 reset x_max", int'(dirty_x_max), 0);
    chk("R9 reset y_min", int'(dirty_y_min), 1023);
    chk("R9 reset y_max", int'(dirty_y_max), 0);

    fill("R8 empty cols",         300, 3,  200, 9,  0,   7,    1'b0);
    fill("R8 R3 neg lw empty",     20, 10,  40, 12, -20, 7,    1'b0);
    fill("R2 basic",               10, 5,   14, 7,  0,   7,    1'b0);
    fill("R2 R3 lw8 code0",       100, 20, 103, 20, 8,   0,    1'b0);
    fill("R5 code other lw3",       0, 0,    3, 0,  3,   8'h33, 1'b0);
    fill("R4 width cap",            5, 30, 2000, 31, 0,  7,    1'b0);
    fill("R3 row cap",           1276, 1020, 1280, 1023, 16, 1, 1'b0);
    fill("R1 start while busy",    40, 40,  45, 42, 0,   0,    1'b1);

    // R1: a different command code is ignored
    cmd_word = 32'h412; lw_word = 0; attr_word = 32'h70000;
    v1_word = pack_v(0, 0, 0); v2_word = pack_v(8, 8, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 wrong cmd busy", int'(busy), 0);
    repeat (5) begin
      chk("R1 wrong cmd done", int'(done), 0);
      @(negedge clk);
    end
    chk("R1 wrong cmd x_min", int'(dirty_x_min), ex_xmin);
    chk("R1 wrong cmd y_min", int'(dirty_y_min), ex_ymin);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule